// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block is the digital decision loop of a transmit level regulator. An external peak detector watches a feedback copy of the transmitted signal. Two comparators then report whether that peak is above a low threshold and whether it is above a high threshold. The block keeps a 5-bit attenuation index. Each count of the index stands for one fixed decibel step of transmit level, and 32 codes cover roughly 26 dB. Index 0 is the loudest output and the top code is the quietest.

Each time the update strobe is asserted, the block reads the two comparator flags and makes one of three choices. A peak under the window means the output is too quiet, so attenuation drops one step. A peak above the window means the output is too loud, so attenuation rises one step. A peak inside the window leaves the index alone. The index stops at both ends of its range and a flag marks each end. After every strobe the block sends out a one-cycle request that clears the external peak hold, so the next period measures fresh.

Top module: `tx_level_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `gain_idx` becomes 31 (maximum attenuation), `at_max_att` becomes 1, `at_max_out` becomes 0 and `peak_clr` becomes 0.
- R2: On a clock edge where `upd_stb` is 0, `gain_idx` keeps its value whatever the comparator flags are.
- R3: On an edge with `upd_stb`=1, `above_lo`=0 and `above_hi`=0, `gain_idx` decreases by one (more output).
- R4: On an edge with `upd_stb`=1, `above_lo`=1 and `above_hi`=0, `gain_idx` is unchanged.
- R5: On an edge with `upd_stb`=1, `above_lo`=1 and `above_hi`=1, `gain_idx` increases by one (less output).
- R6: The inconsistent pair `above_lo`=0, `above_hi`=1 under a strobe is handled as above the high threshold: `gain_idx` increases by one.
- R7: `gain_idx` saturates. A decrease at 0 leaves it at 0 and an increase at 31 leaves it at 31.
- R8: `at_max_out` is 1 exactly when `gain_idx` is 0, and `at_max_att` is 1 exactly when `gain_idx` is 31. Both update in the same cycle as the index.
- R9: `peak_clr` is 1 for the single cycle after each edge at which `upd_stb` was 1, and 0 otherwise.
- R10: A single strobe changes `gain_idx` by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | Update strobe, one decision per high cycle |
| above_lo | input | 1 | Peak exceeds the low threshold |
| above_hi | input | 1 | Peak exceeds the high threshold |
| gain_idx | output | 5 | Attenuation index, 0 = loudest, 31 = quietest |
| at_max_out | output | 1 | Index is at 0 |
| at_max_att | output | 1 | Index is at 31 |
| peak_clr | output | 1 | One-cycle request to clear the external peak hold |

## Verification
The embedded properties are checked on every cycle. They cover these behaviours:
- the index stays fixed when there is no strobe;
- a strobe moves the index by at most one step;
- the window decision gives the correct direction, including the inconsistent flag pair;
- both ends of the range hold under saturation;
- the limit flags agree with the index;
- the peak-clear pulse follows the strobe.

Only the bench scenarios can show the rest:
- the absolute values of the index after a sequence of decisions;
- the full ramp from maximum attenuation down to the loudest code and the stop there;
- a reset in the middle of operation restoring the safe state.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_RAISE = 2'd1,  // more output: index down
    DEC_LOWER = 2'd2   // less output: index up
  } tlc_dec_t;
endpackage

// File: rtl/tlc_window_dec.sv
module tlc_window_dec
  import tlc_pkg::*;
(
  input  logic     above_lo,
  input  logic     above_hi,
  output tlc_dec_t dec
);
  // High flag wins, so an inconsistent pair still backs the level off.
  always_comb begin
    if (above_hi)       dec = DEC_LOWER;
    else if (!above_lo) dec = DEC_RAISE;
    else                dec = DEC_HOLD;
  end
endmodule

// File: rtl/tlc_gain_idx.sv
module tlc_gain_idx
  import tlc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  tlc_dec_t         dec,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] idx_nxt
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] ONE     = IDX_W'(1);

  always_comb begin
    idx_nxt = idx;
    if (stb) begin
      case (dec)
        DEC_RAISE: if (idx != '0)      idx_nxt = idx - ONE;
        DEC_LOWER: if (idx != IDX_MAX) idx_nxt = idx + ONE;
        default:   idx_nxt = idx;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= IDX_MAX;
    else     idx <= idx_nxt;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(idx));
  p_step_r10: assert property (@(posedge clk) disable iff (rst)
    stb |=> (idx == $past(idx)) || (idx == $past(idx) + ONE) || (idx + ONE == $past(idx)));
  p_sat_top_r7: assert property (@(posedge clk) disable iff (rst)
    (stb && dec == DEC_LOWER && idx == IDX_MAX) |=> idx == IDX_MAX);
  p_sat_bot_r7: assert property (@(posedge clk) disable iff (rst)
    (stb && dec == DEC_RAISE && idx == '0) |=> idx == '0);
endmodule

// File: rtl/tlc_limit_flags.sv
module tlc_limit_flags #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx_nxt,
  output logic             at_zero,
  output logic             at_full
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_zero <= 1'b0;
      at_full <= 1'b1;
    end else begin
      at_zero <= (idx_nxt == '0);
      at_full <= (idx_nxt == IDX_MAX);
    end
  end
endmodule

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl
  import tlc_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_stb,
  input  logic             above_lo,
  input  logic             above_hi,
  output logic [IDX_W-1:0] gain_idx,
  output logic             at_max_out,
  output logic             at_max_att,
  output logic             peak_clr
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] ONE     = IDX_W'(1);

  tlc_dec_t         dec;
  logic [IDX_W-1:0] idx_nxt;

  tlc_window_dec u_dec (
    .above_lo (above_lo),
    .above_hi (above_hi),
    .dec      (dec)
  );

  tlc_gain_idx #(.IDX_W(IDX_W)) u_idx (
    .clk     (clk),
    .rst     (rst),
    .stb     (upd_stb),
    .dec     (dec),
    .idx     (gain_idx),
    .idx_nxt (idx_nxt)
  );

  tlc_limit_flags #(.IDX_W(IDX_W)) u_flg (
    .clk     (clk),
    .rst     (rst),
    .idx_nxt (idx_nxt),
    .at_zero (at_max_out),
    .at_full (at_max_att)
  );

  always_ff @(posedge clk) begin
    if (rst) peak_clr <= 1'b0;
    else     peak_clr <= upd_stb;
  end

  p_raise_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !above_lo && !above_hi && gain_idx != '0) |=> gain_idx + ONE == $past(gain_idx));
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && above_lo && !above_hi) |=> $stable(gain_idx));
  p_lower_r5: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && above_lo && above_hi && gain_idx != IDX_MAX) |=> gain_idx == $past(gain_idx) + ONE);
  p_incons_r6: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && !above_lo && above_hi && gain_idx != IDX_MAX) |=> gain_idx == $past(gain_idx) + ONE);
  p_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (at_max_out == (gain_idx == '0)) && (at_max_att == (gain_idx == IDX_MAX)));
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> peak_clr);
  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !upd_stb |=> !peak_clr);
endmodule

// File: tb/sim_tx_level_ctrl.sv
`timescale 1ns/1ps
module sim_tx_level_ctrl;
  logic       clk = 1'b0;
  logic       rst, upd_stb, above_lo, above_hi;
  logic [4:0] gain_idx;
  logic       at_max_out, at_max_att, peak_clr;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  tx_level_ctrl u0 (
    .clk(clk), .rst(rst), .upd_stb(upd_stb), .above_lo(above_lo),
    .above_hi(above_hi), .gain_idx(gain_idx), .at_max_out(at_max_out),
    .at_max_att(at_max_att), .peak_clr(peak_clr)
  );

  // {stb, lo, hi, expected index}, starting from the reset value 31
  localparam logic [7:0] VEC [12] = '{
    {3'b000, 5'd31},  // R2 no strobe
    {3'b111, 5'd31},  // R7 top saturation
    {3'b110, 5'd31},  // R4 inside window
    {3'b100, 5'd30},  // R3 raise output
    {3'b100, 5'd29},  // R3
    {3'b001, 5'd29},  // R2 flags ignored without strobe
    {3'b101, 5'd30},  // R6 inconsistent pair
    {3'b111, 5'd31},  // R5 lower output
    {3'b100, 5'd30},  // R3
    {3'b110, 5'd30},  // R4
    {3'b111, 5'd31},  // R5
    {3'b011, 5'd31}   // R2
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives, lets one rising edge pass, samples at the next falling edge.
  task automatic step(input logic s, input logic l, input logic h);
    upd_stb = s; above_lo = l; above_hi = h;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic chk_state(input string req, input int exp_idx, input logic exp_clr);
    chk(req, gain_idx, exp_idx);
    chk({req, " R8 max_out"}, at_max_out, exp_idx == 0);
    chk({req, " R8 max_att"}, at_max_att, exp_idx == 31);
    chk({req, " R9 peak_clr"}, peak_clr, exp_clr);
  endtask

  initial begin
    rst = 1'b1; upd_stb = 1'b0; above_lo = 1'b0; above_hi = 1'b0;
    repeat (3) @(negedge clk);
    chk_state("R1 reset", 31, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][7], VEC[i][6], VEC[i][5]);
      chk_state($sformatf("vec%0d", i), VEC[i][4:0], VEC[i][7]);
    end

    // R10: one step per strobe, ramp from 31 all the way down
    for (int k = 30; k >= 0; k--) begin
      step(1'b1, 1'b0, 1'b0);
      chk("R10 ramp", gain_idx, k);
    end
    chk_state("R8 bottom", 0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    chk_state("R7 bottom saturation", 0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk_state("R9 no pulse", 0, 1'b0);
    step(1'b1, 1'b1, 1'b1);
    chk_state("R5 from bottom", 1, 1'b1);

    // R1: reset in the middle of operation
    rst = 1'b1; upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
    chk_state("R1 mid reset", 31, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule